// File: doc/BRIEF.md
# System Configuration Register with Stop-Recovery Timer

This block holds the eight control bits that set up a small controller's watchdog, its low-voltage monitor and its stop-mode behaviour. Software writes the byte through a simple strobe-and-data port and can read it back in the same cycle it asks. Each bit is also brought out as a decoded enable for the neighbouring blocks. A registered output gives the effective "monitor runs while stopped" condition. A combinational output gives the watchdog period that the rate bit selects.

The block also times the recovery from stop mode. A wake event that arrives while stop mode is active starts a counter. The counter produces a one-cycle done pulse after either a short or a long delay. The short delay is used only when the short-recovery bit is set and the wake did not come from a low-voltage reset. Every other wake uses the long delay.

Two reset inputs act on the block. The asynchronous power-on reset clears everything. The synchronous general reset clears everything except the supply-mode bit, which only power-on can clear. A general reset also aborts a recovery count that is running.

Top module: `sys_cfg_recov`

## Requirements
- R1: Power-on reset (`por_n` low) clears all eight register bits, every decoded output and the recovery timer. After power-on, `rd_data` reads 0x00 and `wdt_timeout` equals the slow period.
- R2: When `wr_en` is high at a clock edge and `sys_rst` is low, the register loads `wr_data`. While `rd_en` is high, `rd_data` shows the current register value in that same cycle. While `rd_en` is low, `rd_data` is 0x00.
- R3: A general reset (`sys_rst` high at a clock edge) clears every bit except bit 3, the supply-mode bit, which keeps its value. General reset takes priority over a write in the same cycle.
- R4: The decoded outputs follow these bit positions: bit 7 `wdt_rate_fast`, bit 5 `lvm_rst_dis`, bit 4 `lvm_pwr_dis`, bit 3 `mode_5v`, bit 1 `stop_insn_en`, bit 0 `wdt_dis`. Bit 6 is the monitor-in-stop request and bit 2 is the short-recovery select.
- R5: `wdt_timeout` equals `WDT_FAST_CYC` when bit 7 is 1 and `WDT_SLOW_CYC` when bit 7 is 0.
- R6: `lvm_stop_en` is a flop output equal to bit 6 AND NOT bit 4. It changes on the same clock edge that loads the register.
- R7: A wake with stop active, bit 2 set and `wake_lvr` low gives `recov_done` exactly `SHORT_RECOV_CYC` clock edges after the edge that sampled the wake.
- R8: A wake with stop active and bit 2 clear gives `recov_done` after `LONG_RECOV_CYC` edges.
- R9: A wake sampled with `wake_lvr` high always uses `LONG_RECOV_CYC`, even when bit 2 is set.
- R10: `recov_done` is high for exactly one cycle for each completed recovery.
- R11: A wake is ignored while `stop_active` is low. A wake is also ignored while a count is running; it neither restarts nor extends that count.
- R12: A general reset during a count aborts it, and no `recov_done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous general reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Readback, valid in the cycle of the request |
| stop_active | input | 1 | Stop mode is in effect |
| wake | input | 1 | Wake-up event |
| wake_lvr | input | 1 | Wake was caused by a low-voltage reset |
| wdt_rate_fast | output | 1 | Watchdog fast-rate select |
| lvm_stop_en | output | 1 | Low-voltage monitor enabled during stop (registered) |
| lvm_rst_dis | output | 1 | Low-voltage reset disable |
| lvm_pwr_dis | output | 1 | Low-voltage monitor power disable |
| mode_5v | output | 1 | Supply-mode select, 1 = higher supply |
| stop_insn_en | output | 1 | Stop instruction permitted |
| wdt_dis | output | 1 | Watchdog disable |
| wdt_timeout | output | WDT_W | Selected watchdog period in clock cycles |
| recov_done | output | 1 | One-cycle pulse when stop recovery completes |

## Verification
The bench builds the block with a short recovery of 4 cycles and a long recovery of 20 cycles. With these values every recovery path finishes in a few dozen cycles, so the bench can measure the exact cycle of each done pulse and count the pulses in a window longer than the long delay. That window makes an early pulse, a late pulse, a restarted count or a missed abort show up as a count mismatch. The watchdog periods keep their default values, so the 18-bit timeout output is checked at its real full-width settings.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;

    localparam int CFG_W = 8;

    // Field order is MSB first; neighbours decode these positions.
    typedef struct packed {
        logic wdt_fast;     // 7
        logic lvm_in_stop;  // 6
        logic lvm_rst_off;  // 5
        logic lvm_pwr_off;  // 4
        logic mode_5v;      // 3
        logic short_rec;    // 2
        logic stop_ok;      // 1
        logic wdt_off;      // 0
    } cfg_bits_t;

    // Value left after a general (non power-on) reset.
    function automatic cfg_bits_t after_sys_reset(cfg_bits_t cur);
        cfg_bits_t r;
        r         = '0;
        r.mode_5v = cur.mode_5v;
        return r;
    endfunction

endpackage

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
    import sys_cfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  sys_rst,
    input  logic                  wr_en,
    input  logic [CFG_W-1:0]      wr_data,
    output cfg_bits_t             cfg_o,
    output logic                  lvm_stop_o
);

    typedef struct packed {
        cfg_bits_t cfg;
        logic      lvm_stop;
    } regs_state_t;

    regs_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sys_rst) begin
            s_d.cfg = after_sys_reset(s_q.cfg);
        end else if (wr_en) begin
            s_d.cfg = cfg_bits_t'(wr_data);
        end
        // Flop the combined enable so it cannot glitch while bits change.
        s_d.lvm_stop = s_d.cfg.lvm_in_stop & ~s_d.cfg.lvm_pwr_off;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o      = s_q.cfg;
    assign lvm_stop_o = s_q.lvm_stop;

endmodule

// File: rtl/sys_recov_timer.sv
module sys_recov_timer #(
    parameter int SHORT_CYC = 32,
    parameter int LONG_CYC  = 4096,
    localparam int CNT_W    = $clog2(LONG_CYC + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic stop_active,
    input  logic wake,
    input  logic wake_lvr,
    input  logic short_sel,
    output logic done_o
);

    localparam logic [CNT_W-1:0] SHORT_N = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_N  = CNT_W'(LONG_CYC);

    typedef struct packed {
        logic             busy;
        logic             use_long;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_state_t;

    tmr_state_t       s_d, s_q;
    logic [CNT_W-1:0] target;

    always_comb begin
        target = s_q.use_long ? LONG_N : SHORT_N;
        s_d      = s_q;
        s_d.done = 1'b0;
        if (sys_rst) begin
            s_d = '0;
        end else if (s_q.busy) begin
            if (s_q.cnt == target) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (stop_active && wake) begin
            // Length is fixed at the wake; low-voltage wakes force long.
            s_d.busy     = 1'b1;
            s_d.cnt      = CNT_W'(1);
            s_d.use_long = wake_lvr | ~short_sel;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = s_q.done;

endmodule

// File: rtl/sys_wdt_sel.sv
module sys_wdt_sel #(
    parameter int FAST_CYC = 8176,
    parameter int SLOW_CYC = 262128,
    parameter int W        = 18
) (
    input  logic         fast,
    output logic [W-1:0] timeout
);

    localparam logic [W-1:0] FAST_V = W'(FAST_CYC);
    localparam logic [W-1:0] SLOW_V = W'(SLOW_CYC);

    always_comb begin
        timeout = fast ? FAST_V : SLOW_V;
    end

endmodule

// File: rtl/sys_cfg_recov.sv
module sys_cfg_recov
    import sys_cfg_pkg::*;
#(
    parameter int  SHORT_RECOV_CYC = 32,
    parameter int  LONG_RECOV_CYC  = 4096,
    parameter int  WDT_FAST_CYC    = 8176,
    parameter int  WDT_SLOW_CYC    = 262128,
    localparam int WDT_MAX         = (WDT_FAST_CYC > WDT_SLOW_CYC) ? WDT_FAST_CYC : WDT_SLOW_CYC,
    localparam int WDT_W           = $clog2(WDT_MAX + 1)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    input  logic             stop_active,
    input  logic             wake,
    input  logic             wake_lvr,
    output logic             wdt_rate_fast,
    output logic             lvm_stop_en,
    output logic             lvm_rst_dis,
    output logic             lvm_pwr_dis,
    output logic             mode_5v,
    output logic             stop_insn_en,
    output logic             wdt_dis,
    output logic [WDT_W-1:0] wdt_timeout,
    output logic             recov_done
);

    cfg_bits_t cfg;

    sys_cfg_regs u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst    (sys_rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cfg_o      (cfg),
        .lvm_stop_o (lvm_stop_en)
    );

    sys_recov_timer #(
        .SHORT_CYC (SHORT_RECOV_CYC),
        .LONG_CYC  (LONG_RECOV_CYC)
    ) u_timer (
        .clk         (clk),
        .por_n       (por_n),
        .sys_rst     (sys_rst),
        .stop_active (stop_active),
        .wake        (wake),
        .wake_lvr    (wake_lvr),
        .short_sel   (cfg.short_rec),
        .done_o      (recov_done)
    );

    sys_wdt_sel #(
        .FAST_CYC (WDT_FAST_CYC),
        .SLOW_CYC (WDT_SLOW_CYC),
        .W        (WDT_W)
    ) u_wdt (
        .fast    (cfg.wdt_fast),
        .timeout (wdt_timeout)
    );

    assign rd_data       = rd_en ? 8'(cfg) : 8'h00;
    assign wdt_rate_fast = cfg.wdt_fast;
    assign lvm_rst_dis   = cfg.lvm_rst_off;
    assign lvm_pwr_dis   = cfg.lvm_pwr_off;
    assign mode_5v       = cfg.mode_5v;
    assign stop_insn_en  = cfg.stop_ok;
    assign wdt_dis       = cfg.wdt_off;

endmodule

// File: rtl/sys_cfg_recov_chk.sv
module sys_cfg_recov_chk (
    input logic       clk,
    input logic       por_n,
    input logic       sys_rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       wdt_rate_fast,
    input logic       lvm_stop_en,
    input logic       lvm_pwr_dis,
    input logic       mode_5v,
    input logic       stop_insn_en,
    input logic       wdt_dis,
    input logic       recov_done
);

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !sys_rst) |=> (!rd_en || rd_data == $past(wr_data)));

    // R3
    sys_reset_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (!wdt_rate_fast && !stop_insn_en && !wdt_dis && !lvm_stop_en
                     && mode_5v == $past(mode_5v)));

    // R4
    decode_pos_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_en |-> (stop_insn_en == rd_data[1] && wdt_dis == rd_data[0]
                   && lvm_pwr_dis == rd_data[4] && wdt_rate_fast == rd_data[7]));

    // R6
    lvm_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_en |-> (lvm_stop_en == (rd_data[6] && !rd_data[4])));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        recov_done |=> !recov_done);

    // R12
    abort_no_done_chk: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> !recov_done);

endmodule

bind sys_cfg_recov sys_cfg_recov_chk u_chk (.*);

// File: tb/sys_cfg_recov_test.sv
`timescale 1ns/1ps
module sys_cfg_recov_test;

    localparam int SHORT_N  = 4;
    localparam int LONG_N   = 20;
    localparam int FAST_CYC = 8176;
    localparam int SLOW_CYC = 262128;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        stop_active = 1'b0;
    logic        wake = 1'b0;
    logic        wake_lvr = 1'b0;
    logic        wdt_rate_fast, lvm_stop_en, lvm_rst_dis, lvm_pwr_dis;
    logic        mode_5v, stop_insn_en, wdt_dis, recov_done;
    logic [17:0] wdt_timeout;

    int vecs = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    sys_cfg_recov #(
        .SHORT_RECOV_CYC (SHORT_N),
        .LONG_RECOV_CYC  (LONG_N)
    ) uut (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .stop_active(stop_active), .wake(wake), .wake_lvr(wake_lvr),
        .wdt_rate_fast(wdt_rate_fast), .lvm_stop_en(lvm_stop_en),
        .lvm_rst_dis(lvm_rst_dis), .lvm_pwr_dis(lvm_pwr_dis),
        .mode_5v(mode_5v), .stop_insn_en(stop_insn_en), .wdt_dis(wdt_dis),
        .wdt_timeout(wdt_timeout), .recov_done(recov_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_cfg(output logic [7:0] v);
        rd_en = 1'b1;
        #0.5;
        v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic t_por();
        logic [7:0] v;
        @(negedge clk);
        read_cfg(v);
        chk("R1 readback", 32'(v), 32'h00);
        chk("R1 outputs", {wdt_rate_fast, lvm_stop_en, lvm_rst_dis, lvm_pwr_dis,
                           mode_5v, stop_insn_en, wdt_dis, recov_done}, 32'h0);
        chk("R1 timeout", 32'(wdt_timeout), 32'(SLOW_CYC));
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        write_cfg(8'hA5);
        read_cfg(v);
        chk("R2 readback A5", 32'(v), 32'hA5);
        #0.5;
        chk("R2 idle read zero", 32'(rd_data), 32'h00);
        chk("R4 decode A5", {wdt_rate_fast, lvm_rst_dis, lvm_pwr_dis, mode_5v,
                             stop_insn_en, wdt_dis}, 32'b110001);
        write_cfg(8'h5A);
        read_cfg(v);
        chk("R2 readback 5A", 32'(v), 32'h5A);
        chk("R4 decode 5A", {wdt_rate_fast, lvm_rst_dis, lvm_pwr_dis, mode_5v,
                             stop_insn_en, wdt_dis}, 32'b001110);
    endtask

    task automatic t_wdt();
        write_cfg(8'h80);
        chk("R5 fast period", 32'(wdt_timeout), 32'(FAST_CYC));
        write_cfg(8'h00);
        chk("R5 slow period", 32'(wdt_timeout), 32'(SLOW_CYC));
    endtask

    task automatic t_lvm();
        write_cfg(8'h40);
        chk("R6 enable set", 32'(lvm_stop_en), 32'h1);
        write_cfg(8'h50);
        chk("R6 power off masks", 32'(lvm_stop_en), 32'h0);
        write_cfg(8'h10);
        chk("R6 request clear", 32'(lvm_stop_en), 32'h0);
    endtask

    task automatic t_resets();
        logic [7:0] v;
        write_cfg(8'hFF);
        @(negedge clk);
        sys_rst = 1'b1; wr_en = 1'b1; wr_data = 8'hF7;
        @(negedge clk);
        sys_rst = 1'b0; wr_en = 1'b0;
        read_cfg(v);
        chk("R3 mode bit kept", 32'(v), 32'h08);
        chk("R3 lvm flop cleared", 32'(lvm_stop_en), 32'h0);
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        read_cfg(v);
        chk("R1 power-on clears mode", 32'(v), 32'h00);
    endtask

    // Wake is sampled at edge E; done is expected exp_first edges later.
    task automatic run_recov(input logic [7:0] cfgv, input logic stop, input logic lvr,
                             input int rewake_i, input int abort_i,
                             input int exp_first, input int exp_pulses, input string tag);
        int first = 0;
        int pulses = 0;
        write_cfg(cfgv);
        @(negedge clk);
        stop_active = stop; wake = 1'b1; wake_lvr = lvr;
        @(negedge clk);
        wake = 1'b0; wake_lvr = 1'b0;
        for (int i = 1; i <= LONG_N + 6; i++) begin
            @(posedge clk);
            #1;
            if (recov_done) begin
                pulses++;
                if (first == 0) first = i;
            end
            wake    = (i == rewake_i);
            sys_rst = (i == abort_i);
        end
        wake = 1'b0; sys_rst = 1'b0; stop_active = 1'b0;
        chk(tag, 32'(first), 32'(exp_first));
        chk("R10 pulse count", 32'(pulses), 32'(exp_pulses));
    endtask

    initial begin
        #1000000;
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        t_por();
        t_write_read();
        t_wdt();
        t_lvm();
        t_resets();
        run_recov(8'h04, 1'b1, 1'b0, 0, 0, SHORT_N, 1, "R7 short recovery");
        run_recov(8'h00, 1'b1, 1'b0, 0, 0, LONG_N, 1, "R8 long recovery");
        run_recov(8'h04, 1'b1, 1'b1, 0, 0, LONG_N, 1, "R9 lvr forces long");
        run_recov(8'h04, 1'b0, 1'b0, 0, 0, 0, 0, "R11 wake without stop");
        run_recov(8'h04, 1'b1, 1'b0, 2, 0, SHORT_N, 1, "R11 rewake ignored");
        run_recov(8'h00, 1'b1, 1'b0, 0, 3, 0, 0, "R12 abort by reset");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule